// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's rows alive by issuing refresh cycles on the DRAM control bus. An interval timer fires once per row slot: the retention period divided by 1024 rows. Each firing adds one to a pending-refresh backlog. While the backlog is nonzero the block requests the bus from the access controller. When the controller grants it, the block runs one refresh cycle and then retires one backlog entry.

Three refresh styles are offered and chosen per grant. The first is CS-before-RAS, which relies on the DRAM's own row counter. The second is a row-address refresh, which strobes RAS with CS high and drives a row from an internal counter. The third is hidden refresh, in which CS stays low after a read while RAS precharges and strobes again. A low-power input selects the longer retention interval. Write enable is held high in every style, so a CS-before-RAS cycle never becomes a test-mode entry.

The access controller owns the bus mux. For a hidden refresh it keeps CS low from the end of its read until this block's CS takes over. The active phase (`RAS_CYC`) must be at least two cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: With `low_power_i` low, `req_o` first rises exactly `REFI_STD_CYC` clock edges after reset is released. A further backlog entry is added every `REFI_STD_CYC` edges after that.
- R2: With `low_power_i` high, the interval is `REFI_LP_CYC` edges instead.
- R3: `req_o` is high exactly while the backlog is nonzero. A completed refresh removes one entry, so a single pending entry drops `req_o` on the edge that ends the cycle.
- R4: `overflow_o` is set when an interval expires while the backlog already holds `MAX_BACKLOG` (8) entries. It stays set until reset.
- R5: A grant starts a refresh only while the block is idle and `req_o` is high; any other grant has no effect. `mode_i` is sampled only on the accepting edge.
- R6: Mode 0 (CS-before-RAS), and mode 3 which behaves the same, runs three phases. First, `SETUP_CYC` cycles with CS low and RAS high. Then `RAS_CYC` cycles with both low. Then `PRECH_CYC` cycles with both high. `addr_o` stays 0 throughout.
- R7: Mode 1 (row address) keeps CS high for the whole cycle. It uses the same RAS phases as mode 0 and drives the row counter on `addr_o` for the whole busy period. The counter increments after each such refresh and wraps from 2^ROW_W-1 to 0.
- R8: Mode 2 (hidden) holds CS low through a `PRECH_CYC`-long RAS precharge and through the `RAS_CYC` active phase. It then runs `PRECH_CYC` cycles with both high.
- R9: `busy_o` is high from the accepting edge for the whole refresh. While idle, RAS and CS are high and `addr_o` is 0.
- R10: Refreshes in modes 0, 2 and 3 leave the row counter unchanged.
- R11: `we_n_o` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_power_i | input | 1 | Selects the long retention interval |
| mode_i | input | 2 | Refresh style: 0 CS-before-RAS, 1 row address, 2 hidden, 3 as 0 |
| grant_i | input | 1 | Bus grant from the access controller |
| req_o | output | 1 | Refresh request |
| busy_o | output | 1 | Refresh cycle in progress |
| overflow_o | output | 1 | Backlog exceeded its limit (sticky) |
| ras_n_o | output | 1 | Row strobe, active low |
| cs_n_o | output | 1 | Column/chip select, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_W (10) | Row address for row-address refresh |

## Verification
The bench runs a 4-bit row counter and short intervals. It sweeps all four mode codes in a sequence that interleaves row-address refreshes with the other styles. This separates a counter that advances on every refresh from one that advances only in mode 1, and it drives the counter past its wrap point. Every refresh is compared cycle by cycle against a phase pattern computed from the phase lengths, so a wrong phase length or a wrong CS level per style shows up. Changing `mode_i` right after acceptance, holding grant across a whole cycle, and granting with no request each separate a correctly latched handshake from one that re-samples its inputs. Counting edges to the first request under both interval settings, and to overflow after nine intervals, pins down the timer and backlog limits.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic [1:0] {
    MODE_CBR    = 2'd0,
    MODE_ROWADR = 2'd1,
    MODE_HIDDEN = 2'd2
  } ref_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } seq_state_e;
endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
  parameter int STD_CYC = 1953,
  parameter int LP_CYC  = 15625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_power_i,
  output logic tick_o
);
  localparam int MAXC = (STD_CYC > LP_CYC) ? STD_CYC : LP_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STD_LIM = CW'(STD_CYC - 1);
  localparam logic [CW-1:0] LP_LIM  = CW'(LP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = low_power_i ? LP_LIM : STD_LIM;
  // >= keeps the timer sane when the setting shrinks mid-count
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refsch_backlog.sv
module refsch_backlog #(
  parameter int MAX_BACKLOG = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic pending_o,
  output logic overflow_o
);
  localparam int BW = $clog2(MAX_BACKLOG + 1);
  localparam logic [BW-1:0] CAP = BW'(MAX_BACKLOG);

  logic [BW-1:0] cnt_q;
  logic          ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tick_i && !done_i) begin
        if (cnt_q == CAP) ovf_q <= 1'b1;
        else              cnt_q <= cnt_q + 1'b1;
      end else if (done_i && !tick_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pending_o  = (cnt_q != '0);
  assign overflow_o = ovf_q;
endmodule

// File: rtl/refsch_sequencer.sv
module refsch_sequencer
  import refsch_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int RAS_CYC   = 10,
  parameter int PRECH_CYC = 8,
  parameter int ROW_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic             pending_i,
  input  logic [1:0]       mode_i,
  output logic             ras_n_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int M1 = (SETUP_CYC > RAS_CYC) ? SETUP_CYC : RAS_CYC;
  localparam int MAXP = (M1 > PRECH_CYC) ? M1 : PRECH_CYC;
  localparam int PW = $clog2(MAXP + 1);
  localparam logic [PW-1:0] SU_LAST = PW'(SETUP_CYC - 1);
  localparam logic [PW-1:0] RA_LAST = PW'(RAS_CYC - 1);
  localparam logic [PW-1:0] RP_LAST = PW'(PRECH_CYC - 1);

  seq_state_e       state_q;
  ref_mode_e        mode_q;
  logic [PW-1:0]    ph_q;
  logic [PW-1:0]    ph_last;
  logic [ROW_W-1:0] row_q;
  logic             accept, last;

  assign accept = (state_q == ST_IDLE) && grant_i && pending_i;

  always_comb begin
    unique case (state_q)
      ST_SETUP:  ph_last = (mode_q == MODE_HIDDEN) ? RP_LAST : SU_LAST;
      ST_ACTIVE: ph_last = RA_LAST;
      ST_PRECH:  ph_last = RP_LAST;
      default:   ph_last = '0;
    endcase
  end

  assign last   = (ph_q == ph_last);
  assign done_o = (state_q == ST_PRECH) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_CBR;
      ph_q    <= '0;
    end else if (accept) begin
      state_q <= ST_SETUP;
      mode_q  <= (mode_i == 2'd3) ? MODE_CBR : ref_mode_e'(mode_i);
      ph_q    <= '0;
    end else if (state_q != ST_IDLE) begin
      if (last) begin
        ph_q <= '0;
        unique case (state_q)
          ST_SETUP:  state_q <= ST_ACTIVE;
          ST_ACTIVE: state_q <= ST_PRECH;
          default:   state_q <= ST_IDLE;
        endcase
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              row_q <= '0;
    else if (done_o && mode_q == MODE_ROWADR) row_q <= row_q + 1'b1;
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign ras_n_o = (state_q != ST_ACTIVE);
  assign cs_n_o  = !((state_q == ST_SETUP || state_q == ST_ACTIVE) && mode_q != MODE_ROWADR);
  // WE never low: avoids the test-mode entry variant of CS-before-RAS
  assign we_n_o  = 1'b1;
  assign addr_o  = (busy_o && mode_q == MODE_ROWADR) ? row_q : '0;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int REFI_STD_CYC = 1953,
  parameter int REFI_LP_CYC  = 15625,
  parameter int MAX_BACKLOG  = 8,
  parameter int SETUP_CYC    = 2,
  parameter int RAS_CYC      = 10,
  parameter int PRECH_CYC    = 8,
  parameter int ROW_W        = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             low_power_i,
  input  logic [1:0]       mode_i,
  input  logic             grant_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             overflow_o,
  output logic             ras_n_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  logic tick, done, pending;

  refsch_interval_timer #(
    .STD_CYC(REFI_STD_CYC),
    .LP_CYC (REFI_LP_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .low_power_i(low_power_i),
    .tick_o     (tick)
  );

  refsch_backlog #(
    .MAX_BACKLOG(MAX_BACKLOG)
  ) u_backlog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .done_i    (done),
    .pending_o (pending),
    .overflow_o(overflow_o)
  );

  refsch_sequencer #(
    .SETUP_CYC(SETUP_CYC),
    .RAS_CYC  (RAS_CYC),
    .PRECH_CYC(PRECH_CYC),
    .ROW_W    (ROW_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .grant_i  (grant_i),
    .pending_i(pending),
    .mode_i   (mode_i),
    .ras_n_o  (ras_n_o),
    .cs_n_o   (cs_n_o),
    .we_n_o   (we_n_o),
    .addr_o   (addr_o),
    .busy_o   (busy_o),
    .done_o   (done)
  );

  assign req_o = pending;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             grant_i,
  input logic             req_o,
  input logic             busy_o,
  input logic             overflow_o,
  input logic             ras_n_o,
  input logic             cs_n_o,
  input logic [ROW_W-1:0] addr_o
);
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r5_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(grant_i) && $past(req_o)));

  // R6 R8: CS already low before RAS falls
  a_r6_cs_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cs_n_o) |-> $past(!cs_n_o));

  a_r6_cs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cs_n_o) |=> !cs_n_o);

  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));

  a_r9_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && cs_n_o && addr_o == '0));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .grant_i   (grant_i),
  .req_o     (req_o),
  .busy_o    (busy_o),
  .overflow_o(overflow_o),
  .ras_n_o   (ras_n_o),
  .cs_n_o    (cs_n_o),
  .addr_o    (addr_o)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int STD  = 12;
  localparam int LP   = 30;
  localparam int MAXB = 8;
  localparam int SU   = 2;
  localparam int RASC = 4;
  localparam int RP   = 3;
  localparam int RW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, low_power, grant;
  logic [1:0]    mode;
  logic          req, busy, ovf, ras_n, cs_n, we_n;
  logic [RW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int row = 0;

  dram_refresh_sched #(
    .REFI_STD_CYC(STD), .REFI_LP_CYC(LP), .MAX_BACKLOG(MAXB),
    .SETUP_CYC(SU), .RAS_CYC(RASC), .PRECH_CYC(RP), .ROW_W(RW)
  ) u_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .low_power_i(low_power), .mode_i(mode),
    .grant_i(grant), .req_o(req), .busy_o(busy), .overflow_o(ovf),
    .ras_n_o(ras_n), .cs_n_o(cs_n), .we_n_o(we_n), .addr_o(addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic lp);
    rst_n = 1'b0; grant = 1'b0; low_power = lp; mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    row = 0;
  endtask

  // waits for a request, grants it and checks every cycle of the refresh
  task automatic run_refresh(input logic [1:0] m, input bit hold, input bit idle_after);
    int su, total;
    bit ro, hid;
    string tg;
    while (!req) @(negedge clk);
    ro  = (m == 2'd1);
    hid = (m == 2'd2);
    su  = hid ? RP : SU;
    total = su + RASC + RP;
    tg = ro ? "R7" : (hid ? "R8" : "R6");
    mode = m; grant = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      chk("R9 busy", busy, 1);
      chk({tg, " ras"}, ras_n, !(i >= su && i < su + RASC));
      chk({tg, " cs"}, cs_n, ro ? 1 : !(i < su + RASC));
      chk(ro ? "R7 R10 addr" : "R6 addr", addr, ro ? row : 0);
      chk("R11 we", we_n, 1);
      if (i == 0) begin
        if (!hold) grant = 1'b0;
        mode = ~m;  // R5: later mode changes must not matter
      end
    end
    @(negedge clk);
    chk("R9 busy end", busy, 0);
    chk("R9 ras idle", ras_n, 1);
    chk("R9 cs idle", cs_n, 1);
    if (idle_after) chk("R3 req drops", req, 0);
    if (hold) begin
      @(negedge clk);
      chk("R5 held grant no restart", busy, 0);
      grant = 1'b0;
    end
    if (ro) row = (row + 1) % (1 << RW);
  endtask

  initial begin
    logic [1:0] seq [21];
    seq = '{2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1, 2'd3, 2'd1, 2'd1, 2'd1,
            2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1};

    // segment 1: standard interval, all modes, row wrap
    do_reset(1'b0);
    chk("R3 reset req", req, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset ras", ras_n, 1);
    chk("R9 reset cs", cs_n, 1);
    chk("R9 reset addr", addr, 0);
    chk("R11 reset we", we_n, 1);
    chk("R4 reset ovf", ovf, 0);
    grant = 1'b1;                 // R5: grant with empty backlog
    @(negedge clk);
    grant = 1'b0;
    chk("R5 ignored grant busy", busy, 0);
    chk("R5 ignored grant ras", ras_n, 1);
    repeat (STD - 2) @(negedge clk);
    chk("R1 before interval", req, 0);
    @(negedge clk);
    chk("R1 at interval", req, 1);
    for (int k = 0; k < 21; k++) run_refresh(seq[k], k == 1, 1'b1);

    // segment 2: low-power interval
    do_reset(1'b1);
    repeat (LP - 1) @(negedge clk);
    chk("R2 before interval", req, 0);
    @(negedge clk);
    chk("R2 at interval", req, 1);
    run_refresh(2'd1, 1'b0, 1'b1);

    // segment 3: backlog overflow
    do_reset(1'b0);
    repeat (9 * STD - 1) @(negedge clk);
    chk("R4 no overflow at limit", ovf, 0);
    chk("R3 req with backlog", req, 1);
    @(negedge clk);
    chk("R4 overflow", ovf, 1);
    run_refresh(2'd0, 1'b0, 1'b0);
    run_refresh(2'd2, 1'b0, 1'b0);
    chk("R4 overflow sticky", ovf, 1);
    chk("R3 req still pending", req, 1);
    do_reset(1'b0);
    @(negedge clk);
    chk("R4 overflow cleared by reset", ovf, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule